// File: doc/BRIEF.md
# Low-Power Mode Command Sequencer

This block steps a processor core into and out of a low-power state by running a short program of byte commands. Firmware fills a small local command memory and sets an enable bit and a start index through a plain write port. Several modes can live in the same memory, each starting at its own offset. Nothing happens until the core reports that it has reached its wait-for-interrupt point. The sequencer then runs the commands in order from the start index.

A command can do one of four things. It can drive a 7-bit power-control port. It can pause for one of three preset delays, counted in ticks of a divided clock. It can stall until a wake interrupt arrives. Or it can mark the end of the program. Reaching the end marker hands the core back with a one-cycle resume pulse. If the program runs off the top of the memory without an end marker, it is cut short and an error pulse is raised.

Write map (`wr_addr`):
- 0x00: control word. Bit 0 is the enable; bits starting at 8 hold the start index.
- 0x01: divider N, in the low bits.
- 0x02: the three delay presets. Preset 0 is in bits [9:0], preset 1 in [19:10] and preset 2 in [29:20].
- Addresses with bit 7 set write the command byte `wr_data[7:0]` at index `wr_addr[ADDR_W-1:0]`.

Top module: `lpmseq_top`

## Requirements
- R1: After reset, busy, done, err, resume and pwr_ctl are all 0.
- R2: When enabled and idle, a cycle with wfi_req high makes busy rise at the next clock edge. cur_idx then equals the programmed start index.
- R3: With the enable bit 0, wfi_req starts nothing, and busy stays 0.
- R4: Commands run strictly in order, and each takes two cycles (fetch, then execute) plus the extra cycles of its own kind.
- R5: A byte that is not a wait, delay or end command drives its low 7 bits onto pwr_ctl. Those bits are held until the next such byte.
- R6: A byte whose upper nibble is 1, 2 or 3 is a delay using preset 0, 1 or 2. It adds V*(N+1)+1 cycles, where V is the preset value and N is the divider.
- R7: A byte with bit 7 set stalls the sequence until wake_irq is sampled high. With wake_irq already high, the stall costs one extra cycle.
- R8: Byte 0x0F ends the sequence. busy falls, and done and resume each pulse high for exactly one cycle, in the first cycle with busy low.
- R9: If the command at the last memory index finishes without being 0x0F, the run stops. busy falls and err and resume pulse for one cycle, with done staying 0.
- R10: Every write through the register port is ignored while busy is high. This covers command bytes, the start index, the enable bit, the divider and the presets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register or command-memory address |
| wr_data | input | 32 | Write data |
| wfi_req | input | 1 | Core has executed wait-for-interrupt |
| wake_irq | input | 1 | Wake interrupt |
| pwr_ctl | output | 7 | Power-control output port |
| busy | output | 1 | Sequence running; core held |
| cur_idx | output | ADDR_W | Index of the current command |
| done | output | 1 | One-cycle pulse on reaching the end marker |
| err | output | 1 | One-cycle pulse on running past the last index |
| resume | output | 1 | One-cycle pulse releasing the core |

## Verification
busy rises one edge after the cycle in which wfi_req is seen. From then on, busy stays high for exactly the sum of the command costs. Each command costs two cycles, a delay adds V*(N+1)+1 and a wait with wake already high adds one. The end-of-run pulses appear in the first cycle with busy low. The bench drives inputs and samples on falling edges and counts the busy cycles of each run. It compares that count against a cost total worked out arithmetically from the programmed bytes, the divider and the presets. It then reads pwr_ctl and the pulses in the cycle right after busy drops.

// File: rtl/lpmseq_pkg.sv
package lpmseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EXEC,
    ST_DELAY,
    ST_WAIT
  } seq_st_t;

  typedef enum logic [1:0] {
    K_OUT,
    K_DLY,
    K_WAIT,
    K_END
  } cmd_kind_t;

  localparam logic [7:0] CMD_END = 8'h0F;

  function automatic cmd_kind_t classify(input logic [7:0] b);
    if (b[7])
      return K_WAIT;
    else if (b == CMD_END)
      return K_END;
    else if (b[6:4] inside {3'd1, 3'd2, 3'd3})
      return K_DLY;
    else
      return K_OUT;
  endfunction

endpackage

// File: rtl/lpmseq_mem.sv
module lpmseq_mem #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/lpmseq_tick.sv
module lpmseq_tick #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (cnt_q == div)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == div) && !clr;
endmodule

// File: rtl/lpmseq_delay.sv
module lpmseq_delay #(
  parameter int DLY_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (dec && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/lpmseq_top.sv
module lpmseq_top
  import lpmseq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DLY_W  = 10,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              wfi_req,
  input  logic              wake_irq,
  output logic [6:0]        pwr_ctl,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_idx,
  output logic              done,
  output logic              err,
  output logic              resume
);
  localparam int          NPRE    = 3;
  localparam int          PRE_W   = NPRE * DLY_W;
  localparam logic [ADDR_W-1:0] LAST_IDX = '1;

  seq_st_t             st_q;
  logic [ADDR_W-1:0]   pc_q;
  logic                en_q;
  logic [ADDR_W-1:0]   start_q;
  logic [DIV_W-1:0]    div_q;
  logic [PRE_W-1:0]    pre_q;
  logic [6:0]          pwr_q;
  logic                busy_q, done_q, err_q, resume_q;

  logic                wr_ok, mem_we;
  logic [7:0]          cmd;
  cmd_kind_t           kind;
  logic [DLY_W-1:0]    pre_sel;
  logic                tick, dly_zero, dly_load, dly_dec;

  assign wr_ok  = wr_en && !busy_q;
  assign mem_we = wr_ok && wr_addr[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      start_q <= '0;
      div_q   <= '0;
      pre_q   <= '0;
    end else if (wr_ok && !wr_addr[7]) begin
      case (wr_addr[1:0])
        2'd0: begin
          en_q    <= wr_data[0];
          start_q <= wr_data[8 +: ADDR_W];
        end
        2'd1: div_q <= wr_data[DIV_W-1:0];
        2'd2: pre_q <= wr_data[PRE_W-1:0];
        default: ;
      endcase
    end
  end

  lpmseq_mem #(.AW(ADDR_W), .DW(8)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (wr_addr[ADDR_W-1:0]),
    .wdata (wr_data[7:0]),
    .raddr (pc_q),
    .rdata (cmd)
  );

  assign kind = classify(cmd);

  always_comb begin
    case (cmd[5:4])
      2'd1:    pre_sel = pre_q[0*DLY_W +: DLY_W];
      2'd2:    pre_sel = pre_q[1*DLY_W +: DLY_W];
      default: pre_sel = pre_q[2*DLY_W +: DLY_W];
    endcase
  end

  assign dly_load = (st_q == ST_EXEC) && (kind == K_DLY);
  assign dly_dec  = (st_q == ST_DELAY) && tick;

  lpmseq_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (dly_load),
    .div  (div_q),
    .tick (tick)
  );

  lpmseq_delay #(.DLY_W(DLY_W)) u_dly (
    .clk      (clk),
    .rst      (rst),
    .load     (dly_load),
    .load_val (pre_sel),
    .dec      (dly_dec),
    .zero     (dly_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      pc_q     <= '0;
      pwr_q    <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      resume_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (en_q && wfi_req) begin
            pc_q   <= start_q;
            busy_q <= 1'b1;
            st_q   <= ST_FETCH;
          end
        end
        ST_FETCH: st_q <= ST_EXEC;
        ST_EXEC: begin
          case (kind)
            K_END: begin
              busy_q   <= 1'b0;
              done_q   <= 1'b1;
              resume_q <= 1'b1;
              st_q     <= ST_IDLE;
            end
            K_WAIT: st_q <= ST_WAIT;
            K_DLY:  st_q <= ST_DELAY;
            default: begin
              pwr_q <= cmd[6:0];
              if (pc_q == LAST_IDX) begin
                busy_q   <= 1'b0;
                err_q    <= 1'b1;
                resume_q <= 1'b1;
                st_q     <= ST_IDLE;
              end else begin
                pc_q <= pc_q + 1'b1;
                st_q <= ST_FETCH;
              end
            end
          endcase
        end
        ST_DELAY, ST_WAIT: begin
          if ((st_q == ST_DELAY && dly_zero) || (st_q == ST_WAIT && wake_irq)) begin
            if (pc_q == LAST_IDX) begin
              busy_q   <= 1'b0;
              err_q    <= 1'b1;
              resume_q <= 1'b1;
              st_q     <= ST_IDLE;
            end else begin
              pc_q <= pc_q + 1'b1;
              st_q <= ST_FETCH;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign pwr_ctl = pwr_q;
  assign busy    = busy_q;
  assign cur_idx = pc_q;
  assign done    = done_q;
  assign err     = err_q;
  assign resume  = resume_q;
endmodule

// File: rtl/lpmseq_checks.sv
module lpmseq_checks (
  input logic       clk,
  input logic       rst,
  input logic       wfi_req,
  input logic [6:0] pwr_ctl,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       resume
);
  // R2: a run only starts after a sampled wait-for-interrupt request
  assert_start_needs_wfi_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wfi_req));

  // R5: the power port only moves while a sequence runs
  assert_pwr_quiet_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(busy) |-> $stable(pwr_ctl));

  // R8: resume only in the cycle right after busy drops
  assert_resume_after_busy_R8: assert property (@(posedge clk) disable iff (rst)
    resume |-> (!busy && $past(busy)));

  // R8: done lasts exactly one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: an overrun never reports completion, and always releases the core
  assert_err_excl_R9: assert property (@(posedge clk) disable iff (rst)
    err |-> (!done && resume));

  // R8: completion always releases the core
  assert_done_resume_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> resume);
endmodule

bind lpmseq_top lpmseq_checks u_checks (
  .clk     (clk),
  .rst     (rst),
  .wfi_req (wfi_req),
  .pwr_ctl (pwr_ctl),
  .busy    (busy),
  .done    (done),
  .err     (err),
  .resume  (resume)
);

// File: tb/lpmseq_top_tb_top.sv
module lpmseq_top_tb_top;
  localparam int AW  = 5;
  localparam int DEP = 1 << AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wfi_req = 1'b0;
  logic        wake_irq = 1'b1;
  logic [6:0]  pwr_ctl;
  logic        busy, done, err, resume;
  logic [AW-1:0] cur_idx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] img [DEP];
  int pre [3];
  int divn;

  lpmseq_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wfi_req(wfi_req), .wake_irq(wake_irq), .pwr_ctl(pwr_ctl), .busy(busy),
    .cur_idx(cur_idx), .done(done), .err(err), .resume(resume)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, act %0d cycles exp <150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put(input int idx, input logic [7:0] b);
    img[idx] = b;
    wr(8'h80 | 8'(idx), {24'd0, b});
  endtask

  task automatic set_cfg(input int start, input int dv, input int p0, input int p1, input int p2);
    divn = dv; pre[0] = p0; pre[1] = p1; pre[2] = p2;
    wr(8'h00, 32'(1) | (32'(start) << 8));
    wr(8'h01, 32'(dv));
    wr(8'h02, 32'(p0) | (32'(p1) << 10) | (32'(p2) << 20));
  endtask

  // cost from the requirements (R4, R6, R7) with wake held high
  task automatic expect_run(input int start, output int cost, output int pwr_last, output bit ends_err);
    int pc;
    pc = start; cost = 0; ends_err = 1'b0;
    forever begin
      logic [7:0] b;
      b = img[pc];
      cost += 2;
      if (b == 8'h0F) break;
      if (b[7]) cost += 1;
      else if (b[6:4] >= 3'd1 && b[6:4] <= 3'd3) cost += pre[b[5:4]-1] * (divn + 1) + 1;
      else pwr_last = int'(b[6:0]);
      if (pc == DEP - 1) begin ends_err = 1'b1; break; end
      pc++;
    end
  endtask

  task automatic launch(output int idx0);
    @(negedge clk); wfi_req = 1'b1;
    @(negedge clk); wfi_req = 1'b0;
    idx0 = int'(cur_idx);
  endtask

  task automatic run_and_check(input int start, input string tag, input int pwr_before);
    int cost, pl, cnt, idx0;
    bit ee;
    pl = pwr_before;
    expect_run(start, cost, pl, ee);
    launch(idx0);
    chk(busy === 1'b1, {tag, " R2 busy rises"}, int'(busy), 1);
    chk(idx0 == start, {tag, " R2 start index"}, idx0, start);
    cnt = 0;
    while (busy === 1'b1) begin cnt++; @(negedge clk); end
    chk(cnt == cost, {tag, " R4 R6 R7 busy cycles"}, cnt, cost);
    chk(int'(pwr_ctl) == pl, {tag, " R5 final pwr_ctl"}, int'(pwr_ctl), pl);
    if (ee) begin
      chk(err === 1'b1 && done === 1'b0 && resume === 1'b1, {tag, " R9 overrun pulses"},
          int'({err, done, resume}), 5);
    end else begin
      chk(done === 1'b1 && err === 1'b0 && resume === 1'b1, {tag, " R8 end pulses"},
          int'({err, done, resume}), 3);
    end
    @(negedge clk);
    chk(done === 1'b0 && resume === 1'b0 && err === 1'b0, {tag, " R8 one-cycle pulses"},
        int'({err, done, resume}), 0);
  endtask

  initial begin
    int idx0, cnt;
    for (int i = 0; i < DEP; i++) img[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0 && resume === 1'b0 && pwr_ctl === 7'd0,
        "R1 reset state", int'({busy, done, err, resume}), 0);

    // R3: disabled sequencer ignores wfi
    @(negedge clk); wfi_req = 1'b1;
    repeat (4) @(negedge clk);
    wfi_req = 1'b0;
    chk(busy === 1'b0, "R3 wfi ignored when disabled", int'(busy), 0);

    // program A at 0 and B at 10
    put(0, 8'h05); put(1, 8'h12); put(2, 8'h80); put(3, 8'h2A);
    put(4, 8'h3F); put(5, 8'h66); put(6, 8'h0F);
    put(10, 8'h4C); put(11, 8'h0E); put(12, 8'h1F); put(13, 8'h7F);
    put(14, 8'h30); put(15, 8'h0F);

    for (int dv = 0; dv < 4; dv++) begin
      for (int ps = 0; ps < 2; ps++) begin
        for (int sq = 0; sq < 2; sq++) begin
          int st;
          st = (sq == 0) ? 0 : 10;
          if (ps == 0) set_cfg(st, dv, 3, 0, 5);
          else         set_cfg(st, dv, 1, 7, 2);
          run_and_check(st, $sformatf("sweep div%0d set%0d seq%0d", dv, ps, sq), int'(pwr_ctl));
        end
      end
    end

    // R9: overrun at top of memory
    put(28, 8'h41); put(29, 8'h42); put(30, 8'h43); put(31, 8'h44);
    set_cfg(28, 0, 1, 1, 1);
    run_and_check(28, "overrun", int'(pwr_ctl));

    // R7 stall plus R10 ignored writes
    put(20, 8'h09); put(21, 8'h81); put(22, 8'h33); put(23, 8'h0F);
    set_cfg(20, 1, 0, 0, 2);
    wake_irq = 1'b0;
    launch(idx0);
    repeat (40) @(negedge clk);
    chk(busy === 1'b1, "R7 stalls without wake", int'(busy), 1);
    chk(pwr_ctl === 7'h09, "R7 pwr held during stall", int'(pwr_ctl), 9);
    wr(8'h80 | 8'd22, 32'h55);
    wr(8'h00, 32'(1) | (32'(0) << 8));
    @(negedge clk); wake_irq = 1'b1;
    cnt = 0;
    while (busy === 1'b1) begin cnt++; @(negedge clk); end
    chk(pwr_ctl === 7'h09, "R10 mem write while busy ignored", int'(pwr_ctl), 9);
    chk(done === 1'b1, "R8 done after wake", int'(done), 1);
    run_and_check(20, "R10 start index kept", int'(pwr_ctl));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule